// File: doc/BRIEF.md
# E1 Doubleframe Alignment Receiver

This block sits on the receive side of a 2.048 Mbit/s E1 line after clock recovery. It takes the serial bit stream one bit per asserted bit enable, with 256 bits per frame and timeslot 0 at the frame start. It locates and holds frame alignment from the alternating words in timeslot 0. Even frames carry the alignment word and odd frames carry the service word.

While hunting, the block compares a sliding window against the alignment pattern on every enabled bit. A candidate alone does not lock the receiver. It must be followed by a valid service word one frame later and a second alignment word one frame after that. If either check fails, the hunt resumes in that third frame just after the spot where the earlier candidate sat. The stream is not slipped by a single bit.

Once aligned, the block publishes its position inside the doubleframe. It also captures the far end's remote alarm bit from each service word and drops alignment after repeated errored alignment words.

Top module: `e1_dframe_sync`

## Requirements
- R1: While reset is active and right after it, `lossOfAlign` is 1 and `alignRecovered`, `remoteAlarm` and `remoteAlarmEvt` are 0.
- R2: The alignment word is the 7-bit pattern 0011011 carried in bits 2..8 of timeslot 0, with bit 1 sent first. Bit 1 is never compared, so its value has no effect on alignment. When a hunt candidate is found on bit 8, `bitPos` reads 7 and `framePhase` reads 0 after that bit.
- R3: Alignment is reached only after three checks pass in order: an alignment word in frame n, a service word in frame n+1 (bit 2 = 1), and an alignment word in frame n+2. At that moment `alignRecovered` pulses for one clock, with `bitPos` = 7 and `framePhase` = 0.
- R4: If the service-word check, the second alignment check, or both fail, no alignment is reached. The hunt restarts on the bit after bit 8 of timeslot 0 in frame n+2, so the alignment word of frame n+2 is never taken as a new candidate.
- R5: `alignRecovered` pulses only when `recEn` was 1 on the bit that completed alignment. Alignment itself does not depend on `recEn`.
- R6: `lossOfAlign` stays 1 through the rest of the doubleframe in which alignment is reached. It falls on the first bit of the next doubleframe (`bitPos` = 0, `framePhase` = 0).
- R7: When aligned, `LOSS_LIMIT` (default 3) consecutive errored alignment words set `lossOfAlign` on bit 8 of the last errored word and restart the hunt. A correct word clears the error run.
- R8: When aligned with `lossOfAlign` = 0, each service word with bit 2 = 1 loads its bit 3 into `remoteAlarm`. `remoteAlarmEvt` pulses for one clock when that load changes `remoteAlarm` from 0 to 1.
- R9: With `bitEn` low, `bitPos`, `framePhase`, `lossOfAlign` and `remoteAlarm` hold their values.
- R10: `framePhase` is 0 in the alignment-word frame and 1 in the service-word frame. `bitPos` counts 0..255 from bit 1 of timeslot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Qualifies `rxBit` for one clock |
| rxBit | input | 1 | Received serial data bit |
| recEn | input | 1 | Enables the alignment-recovered pulse |
| lossOfAlign | output | 1 | 1 while frame alignment is not held |
| alignRecovered | output | 1 | One-clock pulse when alignment is reached |
| bitPos | output | 8 | Position of the last received bit in its frame |
| framePhase | output | 1 | 0 = alignment-word frame, 1 = service-word frame |
| remoteAlarm | output | 1 | Last captured remote alarm bit |
| remoteAlarmEvt | output | 1 | One-clock pulse when the remote alarm sets |

## Verification
The bound checker watches several properties on every clock. The recovered pulse can only appear at bit 8 of an even frame while loss is still flagged, and only when `recEn` was set. Loss may rise only on an alignment slot and fall only at a doubleframe start. The alarm event comes with a set alarm bit at the service-word slot. Positions and flags hold whenever `bitEn` is low. Only the bench's scenarios show the sequence rules: which frame alignment lands in after a failed service word or a failed second alignment word, that the count of errored words before loss is exactly three, and that an ignored bit 1 or gapped enables still lock.

// File: rtl/e1_dfs_pkg.sv
package e1_dfs_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } syncState_t;

  // control -> datapath
  typedef struct packed {
    logic loadPos;    // snap position to the end of the alignment word
    logic captureA;   // load the remote alarm bit from the current word
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic fasHit;     // window matches the alignment pattern on this bit
    logic swHit;      // bit 2 of the current word is 1
    logic atFasSlot;  // this bit is bit 8 of an even-frame timeslot 0
    logic atSwSlot;   // this bit is bit 8 of an odd-frame timeslot 0
    logic atDfStart;  // this bit opens a new doubleframe
  } dpStatus_t;

endpackage

// File: rtl/e1_dfs_datapath.sv
module e1_dfs_datapath
  import e1_dfs_pkg::*;
#(
  parameter int         FRAME_BITS  = 256,
  parameter logic [6:0] FAS_PATTERN = 7'b0011011,
  localparam int        FW          = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          rxBit,
  input  dpStrobe_t     strobe,
  output dpStatus_t     status,
  output logic [FW-1:0] bitPos,
  output logic          framePhase,
  output logic          remoteAlarm,
  output logic          remoteAlarmEvt
);

  localparam int DF_BITS  = 2 * FRAME_BITS;
  localparam int DPW      = FW + 1;
  localparam int HIST_W   = 6;
  localparam int FILL_W   = $clog2(HIST_W + 1);
  localparam logic [DPW-1:0]    FAS_END  = DPW'(7);
  localparam logic [DPW-1:0]    SW_END   = DPW'(FRAME_BITS + 7);
  localparam logic [DPW-1:0]    DF_LAST  = DPW'(DF_BITS - 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST_W);

  logic [HIST_W-1:0] hist;
  logic [FILL_W-1:0] fillCnt;
  logic [DPW-1:0]    pos;
  logic [DPW-1:0]    posInc;
  logic [6:0]        winNext;
  logic              aReg;
  logic              evtReg;

  // bits 2..8 of a candidate word; bit 1 is dropped from the history
  assign winNext = {hist, rxBit};
  assign posInc  = (pos == DF_LAST) ? '0 : pos + 1'b1;

  always_comb begin
    status.fasHit    = bitEn && (fillCnt == FILL_MAX) && (winNext == FAS_PATTERN);
    status.swHit     = winNext[6];
    status.atFasSlot = bitEn && (posInc == FAS_END);
    status.atSwSlot  = bitEn && (posInc == SW_END);
    status.atDfStart = bitEn && (posInc == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist    <= '0;
      fillCnt <= '0;
      pos     <= '0;
    end else if (bitEn) begin
      hist <= winNext[HIST_W-1:0];
      if (fillCnt != FILL_MAX) fillCnt <= fillCnt + 1'b1;
      pos <= strobe.loadPos ? FAS_END : posInc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg   <= 1'b0;
      evtReg <= 1'b0;
    end else begin
      evtReg <= 1'b0;
      if (strobe.captureA) begin
        aReg   <= winNext[5];
        evtReg <= winNext[5] & ~aReg;
      end
    end
  end

  assign bitPos         = pos[FW-1:0];
  assign framePhase     = pos[FW];
  assign remoteAlarm    = aReg;
  assign remoteAlarmEvt = evtReg;

endmodule

// File: rtl/e1_dfs_ctrl.sv
module e1_dfs_ctrl
  import e1_dfs_pkg::*;
#(
  parameter int LOSS_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      recEn,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      lossOfAlign,
  output logic      alignRecovered
);

  localparam int ERR_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_LIMIT - 1);

  syncState_t       state;
  logic             swOk;
  logic [ERR_W-1:0] errCnt;
  logic             loaReg;
  logic             recPulse;

  always_comb begin
    strobe.loadPos  = (state == ST_HUNT) && status.fasHit;
    strobe.captureA = (state == ST_SYNC) && !loaReg && status.atSwSlot && status.swHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      swOk     <= 1'b0;
      errCnt   <= '0;
      loaReg   <= 1'b1;
      recPulse <= 1'b0;
    end else begin
      recPulse <= 1'b0;
      if (bitEn) begin
        case (state)
          ST_HUNT: begin
            if (status.fasHit) begin
              state <= ST_CONFIRM;
              swOk  <= 1'b0;
            end
          end
          ST_CONFIRM: begin
            if (status.atSwSlot) swOk <= status.swHit;
            if (status.atFasSlot) begin
              // either failure sends the hunt on from the bit after this slot
              if (swOk && status.fasHit) begin
                state    <= ST_SYNC;
                errCnt   <= '0;
                recPulse <= recEn;
              end else begin
                state <= ST_HUNT;
              end
            end
          end
          ST_SYNC: begin
            if (loaReg && status.atDfStart) loaReg <= 1'b0;
            if (status.atFasSlot) begin
              if (status.fasHit) begin
                errCnt <= '0;
              end else if (errCnt == ERR_LAST) begin
                errCnt <= '0;
                loaReg <= 1'b1;
                state  <= ST_HUNT;
              end else begin
                errCnt <= errCnt + 1'b1;
              end
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign lossOfAlign    = loaReg;
  assign alignRecovered = recPulse;

endmodule

// File: rtl/e1_dframe_sync.sv
module e1_dframe_sync
  import e1_dfs_pkg::*;
#(
  parameter int         FRAME_BITS  = 256,
  parameter int         LOSS_LIMIT  = 3,
  parameter logic [6:0] FAS_PATTERN = 7'b0011011,
  localparam int        FW          = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          rxBit,
  input  logic          recEn,
  output logic          lossOfAlign,
  output logic          alignRecovered,
  output logic [FW-1:0] bitPos,
  output logic          framePhase,
  output logic          remoteAlarm,
  output logic          remoteAlarmEvt
);

  dpStrobe_t strobe;
  dpStatus_t status;

  e1_dfs_datapath #(
    .FRAME_BITS (FRAME_BITS),
    .FAS_PATTERN(FAS_PATTERN)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .bitEn         (bitEn),
    .rxBit         (rxBit),
    .strobe        (strobe),
    .status        (status),
    .bitPos        (bitPos),
    .framePhase    (framePhase),
    .remoteAlarm   (remoteAlarm),
    .remoteAlarmEvt(remoteAlarmEvt)
  );

  e1_dfs_ctrl #(
    .LOSS_LIMIT(LOSS_LIMIT)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .bitEn         (bitEn),
    .recEn         (recEn),
    .status        (status),
    .strobe        (strobe),
    .lossOfAlign   (lossOfAlign),
    .alignRecovered(alignRecovered)
  );

endmodule

// File: rtl/e1_dfs_checker.sv
module e1_dfs_checker #(
  parameter int  FRAME_BITS = 256,
  localparam int FW         = $clog2(FRAME_BITS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          bitEn,
  input logic          recEn,
  input logic          lossOfAlign,
  input logic          alignRecovered,
  input logic [FW-1:0] bitPos,
  input logic          framePhase,
  input logic          remoteAlarm,
  input logic          remoteAlarmEvt
);

  localparam logic [FW-1:0] SLOT_END = FW'(7);

  a_r3_recover_at_slot: assert property (@(posedge clk) disable iff (!rstN)
    alignRecovered |-> (bitPos == SLOT_END && !framePhase && lossOfAlign));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    alignRecovered |=> !alignRecovered);

  a_r5_pulse_enabled: assert property (@(posedge clk) disable iff (!rstN)
    alignRecovered |-> $past(recEn));

  a_r6_clear_at_df_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossOfAlign) |-> (bitPos == '0 && !framePhase));

  a_r7_loss_at_slot: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossOfAlign) |-> (bitPos == SLOT_END && !framePhase));

  a_r8_event_with_alarm: assert property (@(posedge clk) disable iff (!rstN)
    remoteAlarmEvt |-> (remoteAlarm && bitPos == SLOT_END && framePhase && !lossOfAlign));

  a_r9_hold_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitEn) |-> ($stable(bitPos) && $stable(framePhase) &&
                       $stable(lossOfAlign) && $stable(remoteAlarm)));

endmodule

bind e1_dframe_sync e1_dfs_checker #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .bitEn         (bitEn),
  .recEn         (recEn),
  .lossOfAlign   (lossOfAlign),
  .alignRecovered(alignRecovered),
  .bitPos        (bitPos),
  .framePhase    (framePhase),
  .remoteAlarm   (remoteAlarm),
  .remoteAlarmEvt(remoteAlarmEvt)
);

// File: tb/sim_e1_dframe_sync.sv
`timescale 1ns/1ps
module sim_e1_dframe_sync;

  localparam int         DF_LEN = 512;
  localparam logic [6:0] FASP   = 7'b0011011;
  localparam int         NROWS  = 22;

  // row: {fasOk, swOk, aBit, expLoa, expRec, expEvt, expAlarm}
  localparam logic [6:0] ROWS [NROWS] = '{
    7'b110_1000, 7'b110_1100, 7'b111_0011, 7'b011_0001,
    7'b010_0000, 7'b110_0000, 7'b010_0000, 7'b010_0000,
    7'b010_1000, 7'b100_1000, 7'b110_1000, 7'b110_1000,
    7'b110_1100, 7'b110_0000, 7'b010_0000, 7'b010_0000,
    7'b010_1000, 7'b110_1000, 7'b010_1000, 7'b110_1000,
    7'b110_1100, 7'b110_0000
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b0;
  logic       recEn = 1'b1;
  logic       lossOfAlign, alignRecovered, framePhase, remoteAlarm, remoteAlarmEvt;
  logic [7:0] bitPos;

  int checks = 0;
  int fails  = 0;
  int gap    = 0;
  int recCnt, evtCnt;
  logic       loaAt0, loaAt511, phaseAt7, phaseAt263;
  logic [7:0] posAt7, posAt263;
  bit done = 1'b0;

  e1_dframe_sync u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .recEn(recEn),
    .lossOfAlign(lossOfAlign), .alignRecovered(alignRecovered),
    .bitPos(bitPos), .framePhase(framePhase),
    .remoteAlarm(remoteAlarm), .remoteAlarmEvt(remoteAlarmEvt)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic sendBit(input logic b);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      bitEn = 1'b0;
    end
    @(negedge clk);
    bitEn = 1'b1;
    rxBit = b;
    @(posedge clk);
    #1;
    bitEn = 1'b0;
    if (alignRecovered) recCnt++;
    if (remoteAlarmEvt) evtCnt++;
  endtask

  task automatic sendDf(input logic fasOk, input logic swOk, input logic aBit, input logic b1);
    recCnt = 0;
    evtCnt = 0;
    for (int p = 0; p < DF_LEN; p++) begin
      logic b;
      b = 1'b0;
      if (p == 0 || p == 256) b = b1;
      else if (p >= 1 && p <= 7) b = fasOk ? FASP[7-p] : 1'b0;
      else if (p == 257) b = swOk;
      else if (p == 258) b = aBit;
      sendBit(b);
      if (p == 0)   loaAt0 = lossOfAlign;
      if (p == 7)   begin posAt7 = bitPos; phaseAt7 = framePhase; end
      if (p == 263) begin posAt263 = bitPos; phaseAt263 = framePhase; end
      if (p == 511) loaAt511 = lossOfAlign;
    end
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    bitEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 loss during reset", lossOfAlign, 1);
    doReset();
    check("R1 loss after reset", lossOfAlign, 1);
    check("R1 recovered after reset", alignRecovered, 0);
    check("R1 alarm after reset", remoteAlarm, 0);
    check("R1 alarm event after reset", remoteAlarmEvt, 0);

    // table walk: R3/R4 recovery timing, R7 loss, R8 alarm
    sendZeros(37);
    for (int r = 0; r < NROWS; r++) begin
      logic [6:0] row;
      row = ROWS[r];
      sendDf(row[6], row[5], row[4], 1'b0);
      check($sformatf("R7 loss flag row %0d", r), lossOfAlign, row[3]);
      check($sformatf("R3/R4 recovered pulses row %0d", r), recCnt, row[2]);
      check($sformatf("R8 alarm events row %0d", r), evtCnt, row[1]);
      check($sformatf("R8 alarm bit row %0d", r), remoteAlarm, row[0]);
    end

    // R5 masked pulse, R6 release point, R2 candidate position, R10 phase
    doReset();
    recEn = 1'b0;
    sendZeros(11);
    sendDf(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2 bitPos at candidate", posAt7, 7);
    check("R2 phase at candidate", phaseAt7, 0);
    sendDf(1'b1, 1'b1, 1'b0, 1'b0);
    check("R5 no pulse when disabled", recCnt, 0);
    check("R6 loss held to doubleframe end", loaAt511, 1);
    sendDf(1'b1, 1'b1, 1'b0, 1'b0);
    check("R6 loss clear at first bit", loaAt0, 0);
    check("R10 bitPos in service frame", posAt263, 7);
    check("R10 phase in service frame", phaseAt263, 1);
    recEn = 1'b1;

    // R2 bit 1 set in every word must not disturb alignment
    doReset();
    sendZeros(5);
    sendDf(1'b1, 1'b1, 1'b0, 1'b1);
    sendDf(1'b1, 1'b1, 1'b0, 1'b1);
    check("R2 bit1 ignored pulse", recCnt, 1);
    sendDf(1'b1, 1'b1, 1'b0, 1'b1);
    check("R2 bit1 ignored aligned", lossOfAlign, 0);

    // R9 gapped enables
    doReset();
    gap = 2;
    sendZeros(3);
    sendDf(1'b1, 1'b1, 1'b0, 1'b0);
    sendDf(1'b1, 1'b1, 1'b0, 1'b0);
    check("R9 gapped pulse", recCnt, 1);
    sendDf(1'b1, 1'b1, 1'b1, 1'b0);
    check("R9 gapped aligned", lossOfAlign, 0);
    gap = 0;
    begin
      logic [7:0] heldPos;
      logic       heldPhase;
      heldPos   = bitPos;
      heldPhase = framePhase;
      @(negedge clk);
      rxBit = 1'b1;
      repeat (10) @(negedge clk);
      check("R9 bitPos held", bitPos, heldPos);
      check("R9 phase held", framePhase, heldPhase);
      check("R9 loss held", lossOfAlign, 0);
      check("R9 alarm held", remoteAlarm, 1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule